// File: doc/BRIEF.md
# DMA Peripheral Request Selector

This block sits in front of one DMA channel. It picks one of several on-chip peripheral request lines and hands that request on to the channel engine. A 4-bit source code makes the choice. It can name the first analog converter's conversion-done line or the first timer's compare-match line directly. It can also defer the choice to a 6-bit module code and a 2-bit register code, which together pick the transmit-empty or receive-full line of one of three serial ports.

Before a request is passed on, the block checks the channel's programmed transfer mode and its source and destination addresses against the rules for the chosen requester. A setup that breaks a rule blocks the request and sets a sticky error flag, which software clears with a one-cycle clear strobe. A code combination that names no requester gives no request and raises a config-invalid flag. The forwarded request is registered, so it follows the chosen input by one clock.

Top module: `dma_req_select`

## Requirements
- R1: Source code 4'b1110 selects the analog converter line `adc_req_i`; the module and register codes have no effect on it.
- R2: Source code 4'b1111 selects the timer line `tmr_req_i`; the module and register codes have no effect on it.
- R3: Source code 4'b1000 uses the module code (6'b100010 = port 0, 6'b100100 = port 1, 6'b010000 = port 2) and the register code (2'b00 = transmit-empty `utx_req_i[n]`, 2'b01 = receive-full `urx_req_i[n]`).
- R4: Any other combination drives `cfg_invalid_o` high in the same cycle and never forwards a request.
- R5: With `burst_i` = 1 (burst), requests from the converter and from the serial ports are blocked. Timer requests pass in either mode.
- R6: A transmit request needs `dst_addr_i` equal to that port's transmit register address. A receive request needs `src_addr_i` equal to that port's receive register address. A converter request needs `src_addr_i` equal to the converter data address. A timer request places no condition on either address. All of these addresses are parameters.
- R7: When a selected request arrives under a valid code but a broken rule, it is dropped and `rule_err_o` goes high one cycle later. The flag stays high until `err_clr_i` is sampled high. If a new violation arrives in the same cycle as the clear, the flag stays set.
- R8: `req_o` is the registered result of the selection, one cycle behind the input. After reset, `req_o` and `rule_err_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_code_i | input | 4 | Source code |
| mod_id_i | input | 6 | Module code for the extended selection |
| reg_id_i | input | 2 | Register code for the extended selection |
| burst_i | input | 1 | Channel transfer mode: 1 = burst, 0 = cycle steal |
| src_addr_i | input | AW | Channel source address |
| dst_addr_i | input | AW | Channel destination address |
| adc_req_i | input | 1 | Converter conversion-done request |
| tmr_req_i | input | 1 | Timer compare-match request |
| utx_req_i | input | 3 | Serial port transmit-empty requests |
| urx_req_i | input | 3 | Serial port receive-full requests |
| err_clr_i | input | 1 | Clear strobe for the sticky error flag |
| req_o | output | 1 | Request forwarded to the channel engine |
| cfg_invalid_o | output | 1 | Code combination names no requester |
| rule_err_o | output | 1 | Sticky rule-violation flag |

## Verification
The bench runs every source code against every module code and register code with a legal transfer mode and legal addresses. For each setup it raises each of the eight request lines alone. This shows which single line is routed for each code, and shows that unlisted codes give neither a request nor a clear flag. Targeted setups then break one rule at a time: burst mode, a wrong transmit destination, a wrong receive or converter source, and the address of the wrong port. These separate the mode check from the address check and each requester's rule from the others. A timer with arbitrary addresses in burst mode shows the absence of constraints. Sequences of violation, idle, clear, and violation-with-clear check the flag's hold, clear and set-priority behaviour.

// File: rtl/dma_rsel_pkg.sv
package dma_rsel_pkg;
  localparam int UART_N = 3;

  localparam logic [3:0] SEL_ADC0 = 4'b1110;
  localparam logic [3:0] SEL_TMR0 = 4'b1111;
  localparam logic [3:0] SEL_EXT  = 4'b1000;

  localparam logic [5:0] MID_U0 = 6'b100010;
  localparam logic [5:0] MID_U1 = 6'b100100;
  localparam logic [5:0] MID_U2 = 6'b010000;

  localparam logic [1:0] RID_TX = 2'b00;
  localparam logic [1:0] RID_RX = 2'b01;

  typedef enum logic [1:0] {
    K_ADC = 2'd0,
    K_TMR = 2'd1,
    K_UTX = 2'd2,
    K_URX = 2'd3
  } rq_kind_e;

  typedef struct packed {
    logic     valid;
    rq_kind_e kind;
    logic [1:0] chan;
  } rq_sel_t;
endpackage

// File: rtl/dma_rsel_decode.sv
module dma_rsel_decode
  import dma_rsel_pkg::*;
(
  input  logic [3:0] sel_code_i,
  input  logic [5:0] mod_id_i,
  input  logic [1:0] reg_id_i,
  output rq_sel_t    sel_o
);
  logic       mid_ok;
  logic [1:0] mid_chan;

  always_comb begin
    mid_ok   = 1'b1;
    mid_chan = 2'd0;
    unique case (mod_id_i)
      MID_U0:  mid_chan = 2'd0;
      MID_U1:  mid_chan = 2'd1;
      MID_U2:  mid_chan = 2'd2;
      default: mid_ok   = 1'b0;
    endcase
  end

  always_comb begin
    sel_o = '{valid: 1'b0, kind: K_TMR, chan: 2'd0};
    case (sel_code_i)
      SEL_ADC0: sel_o = '{valid: 1'b1, kind: K_ADC, chan: 2'd0};
      SEL_TMR0: sel_o = '{valid: 1'b1, kind: K_TMR, chan: 2'd0};
      SEL_EXT: begin
        sel_o.chan = mid_chan;
        if (mid_ok && reg_id_i == RID_TX) begin
          sel_o.valid = 1'b1;
          sel_o.kind  = K_UTX;
        end else if (mid_ok && reg_id_i == RID_RX) begin
          sel_o.valid = 1'b1;
          sel_o.kind  = K_URX;
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/dma_rsel_mux.sv
module dma_rsel_mux
  import dma_rsel_pkg::*;
(
  input  rq_sel_t           sel_i,
  input  logic              adc_req_i,
  input  logic              tmr_req_i,
  input  logic [UART_N-1:0] utx_req_i,
  input  logic [UART_N-1:0] urx_req_i,
  output logic              hit_o
);
  logic [3:0] tx_pad, rx_pad;

  always_comb begin
    tx_pad = '0;
    rx_pad = '0;
    tx_pad[UART_N-1:0] = utx_req_i;
    rx_pad[UART_N-1:0] = urx_req_i;
  end

  always_comb begin
    unique case (sel_i.kind)
      K_ADC: hit_o = adc_req_i;
      K_TMR: hit_o = tmr_req_i;
      K_UTX: hit_o = tx_pad[sel_i.chan];
      K_URX: hit_o = rx_pad[sel_i.chan];
    endcase
    hit_o = hit_o & sel_i.valid;
  end
endmodule

// File: rtl/dma_rsel_rules.sv
module dma_rsel_rules
  import dma_rsel_pkg::*;
#(
  parameter int                   AW       = 16,
  parameter logic [AW-1:0]        ADC_ADDR = 16'h4000,
  parameter logic [UART_N*AW-1:0] TX_ADDRS = {16'h5206, 16'h5106, 16'h5006},
  parameter logic [UART_N*AW-1:0] RX_ADDRS = {16'h520A, 16'h510A, 16'h500A}
) (
  input  rq_sel_t       sel_i,
  input  logic          burst_i,
  input  logic [AW-1:0] src_addr_i,
  input  logic [AW-1:0] dst_addr_i,
  output logic          ok_o
);
  logic [3:0] tx_match, rx_match;

  for (genvar g = 0; g < 4; g++) begin : g_port
    if (g < UART_N) begin : g_real
      assign tx_match[g] = (dst_addr_i == TX_ADDRS[g*AW +: AW]);
      assign rx_match[g] = (src_addr_i == RX_ADDRS[g*AW +: AW]);
    end else begin : g_pad
      assign tx_match[g] = 1'b0;
      assign rx_match[g] = 1'b0;
    end
  end

  always_comb begin
    unique case (sel_i.kind)
      K_TMR: ok_o = 1'b1;
      K_ADC: ok_o = !burst_i && (src_addr_i == ADC_ADDR);
      K_UTX: ok_o = !burst_i && tx_match[sel_i.chan];
      K_URX: ok_o = !burst_i && rx_match[sel_i.chan];
    endcase
  end
endmodule

// File: rtl/dma_req_select.sv
module dma_req_select
  import dma_rsel_pkg::*;
#(
  parameter int                   AW       = 16,
  parameter logic [AW-1:0]        ADC_ADDR = 16'h4000,
  parameter logic [UART_N*AW-1:0] TX_ADDRS = {16'h5206, 16'h5106, 16'h5006},
  parameter logic [UART_N*AW-1:0] RX_ADDRS = {16'h520A, 16'h510A, 16'h500A}
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [3:0]        sel_code_i,
  input  logic [5:0]        mod_id_i,
  input  logic [1:0]        reg_id_i,
  input  logic              burst_i,
  input  logic [AW-1:0]     src_addr_i,
  input  logic [AW-1:0]     dst_addr_i,
  input  logic              adc_req_i,
  input  logic              tmr_req_i,
  input  logic [UART_N-1:0] utx_req_i,
  input  logic [UART_N-1:0] urx_req_i,
  input  logic              err_clr_i,
  output logic              req_o,
  output logic              cfg_invalid_o,
  output logic              rule_err_o
);
  rq_sel_t sel;
  logic    hit, ok;
  logic    req_q, err_q;

  dma_rsel_decode u_decode (
    .sel_code_i (sel_code_i),
    .mod_id_i   (mod_id_i),
    .reg_id_i   (reg_id_i),
    .sel_o      (sel)
  );

  dma_rsel_mux u_mux (
    .sel_i     (sel),
    .adc_req_i (adc_req_i),
    .tmr_req_i (tmr_req_i),
    .utx_req_i (utx_req_i),
    .urx_req_i (urx_req_i),
    .hit_o     (hit)
  );

  dma_rsel_rules #(
    .AW       (AW),
    .ADC_ADDR (ADC_ADDR),
    .TX_ADDRS (TX_ADDRS),
    .RX_ADDRS (RX_ADDRS)
  ) u_rules (
    .sel_i      (sel),
    .burst_i    (burst_i),
    .src_addr_i (src_addr_i),
    .dst_addr_i (dst_addr_i),
    .ok_o       (ok)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      req_q <= hit && ok;
      // new violation wins over a clear in the same cycle
      if (hit && !ok)     err_q <= 1'b1;
      else if (err_clr_i) err_q <= 1'b0;
    end
  end

  assign req_o         = req_q;
  assign rule_err_o    = err_q;
  assign cfg_invalid_o = !sel.valid;
endmodule

// File: rtl/dma_req_select_chk.sv
module dma_req_select_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [3:0] sel_code_i,
  input logic       burst_i,
  input logic       adc_req_i,
  input logic       tmr_req_i,
  input logic [2:0] utx_req_i,
  input logic [2:0] urx_req_i,
  input logic       err_clr_i,
  input logic       req_o,
  input logic       cfg_invalid_o,
  input logic       rule_err_o
);
  logic any_req;
  assign any_req = adc_req_i | tmr_req_i | (|utx_req_i) | (|urx_req_i);

  assert_invalid_no_req_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_invalid_o |=> !req_o);

  assert_burst_blocks_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (burst_i && sel_code_i != 4'b1111) |=> !req_o);

  assert_sticky_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rule_err_o && !err_clr_i) |=> rule_err_o);

  assert_err_drops_req_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rule_err_o) |-> !req_o);

  assert_req_lag_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> $past(any_req));
endmodule

bind dma_req_select dma_req_select_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .sel_code_i    (sel_code_i),
  .burst_i       (burst_i),
  .adc_req_i     (adc_req_i),
  .tmr_req_i     (tmr_req_i),
  .utx_req_i     (utx_req_i),
  .urx_req_i     (urx_req_i),
  .err_clr_i     (err_clr_i),
  .req_o         (req_o),
  .cfg_invalid_o (cfg_invalid_o),
  .rule_err_o    (rule_err_o)
);

// File: tb/dma_req_select_bench.sv
`timescale 1ns/1ps
module dma_req_select_bench;
  localparam int AW = 16;
  localparam logic [AW-1:0] ADC_A = 16'h4000;
  localparam logic [AW-1:0] TX_A [3] = '{16'h5006, 16'h5106, 16'h5206};
  localparam logic [AW-1:0] RX_A [3] = '{16'h500A, 16'h510A, 16'h520A};
  localparam logic [AW-1:0] OTHER_S = 16'h0100;
  localparam logic [AW-1:0] OTHER_D = 16'h0200;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [3:0] sel_code = '0;
  logic [5:0] mod_id = '0;
  logic [1:0] reg_id = '0;
  logic burst = 1'b0, err_clr = 1'b0;
  logic [AW-1:0] src = '0, dst = '0;
  logic [7:0] lines = '0; // 0 adc, 1 tmr, 2..4 tx, 5..7 rx
  logic req, cfg_inv, rule_err;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  dma_req_select #(
    .AW(AW), .ADC_ADDR(ADC_A),
    .TX_ADDRS({TX_A[2], TX_A[1], TX_A[0]}),
    .RX_ADDRS({RX_A[2], RX_A[1], RX_A[0]})
  ) u_dma_req_select (
    .clk_i(clk), .rst_ni(rst_n), .sel_code_i(sel_code), .mod_id_i(mod_id),
    .reg_id_i(reg_id), .burst_i(burst), .src_addr_i(src), .dst_addr_i(dst),
    .adc_req_i(lines[0]), .tmr_req_i(lines[1]), .utx_req_i(lines[4:2]),
    .urx_req_i(lines[7:5]), .err_clr_i(err_clr), .req_o(req),
    .cfg_invalid_o(cfg_inv), .rule_err_o(rule_err)
  );

  task automatic chk(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0b expected %0b (code %b mid %b rid %b lines %b)",
               tag, act, exp, sel_code, mod_id, reg_id, lines);
    end
  endtask

  // expected line index, -1 when nothing is selected
  function automatic int exp_line(logic [3:0] c, logic [5:0] m, logic [1:0] r);
    int ch;
    if (c == 4'b1110) return 0;
    if (c == 4'b1111) return 1;
    if (c != 4'b1000) return -1;
    ch = (m == 6'b100010) ? 0 : (m == 6'b100100) ? 1 : (m == 6'b010000) ? 2 : -1;
    if (ch < 0) return -1;
    if (r == 2'b00) return 2 + ch;
    if (r == 2'b01) return 5 + ch;
    return -1;
  endfunction

  // apply at negedge, next negedge sees the registered result
  task automatic cyc(logic [3:0] c, logic [5:0] m, logic [1:0] r, logic b,
                     logic [AW-1:0] s, logic [AW-1:0] d, logic [7:0] l, logic clr);
    sel_code = c; mod_id = m; reg_id = r; burst = b; src = s; dst = d;
    lines = l; err_clr = clr;
    @(negedge clk);
  endtask

  task automatic idle();
    lines = '0; err_clr = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    fails++; checks++;
    $display("FAIL watchdog: actual running expected done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int e;
    logic [AW-1:0] ls, ld;
    repeat (3) @(negedge clk);
    chk("R8 reset req", req, 1'b0);
    chk("R8 reset err", rule_err, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);

    // sweep all codes with legal setup, one line at a time (R1 R2 R3 R4)
    for (int c = 0; c < 16; c++)
      for (int m = 0; m < 64; m++)
        for (int r = 0; r < 4; r++) begin
          e = exp_line(c[3:0], m[5:0], r[1:0]);
          ls = OTHER_S; ld = OTHER_D;
          if (e == 0) ls = ADC_A;
          if (e >= 2 && e <= 4) ld = TX_A[e-2];
          if (e >= 5) ls = RX_A[e-5];
          for (int k = 0; k < 8; k++) begin
            cyc(c[3:0], m[5:0], r[1:0], 1'b0, ls, ld, 8'(1 << k), 1'b0);
            chk(e == 0 ? "R1 adc route" : e == 1 ? "R2 tmr route" :
                e < 0 ? "R4 no req" : "R3 uart route", req, e == k);
          end
          chk("R4 invalid flag", cfg_inv, e < 0);
        end
    idle();
    chk("R7 no err after legal sweep", rule_err, 1'b0);

    // R5 burst
    cyc(4'b1111, 6'h0, 2'd0, 1'b1, 16'h1234, 16'h4321, 8'h02, 1'b0);
    chk("R5 tmr burst passes", req, 1'b1);
    chk("R5 tmr burst no err", rule_err, 1'b0);
    cyc(4'b1110, 6'h0, 2'd0, 1'b1, ADC_A, OTHER_D, 8'h01, 1'b0);
    chk("R5 adc burst blocked", req, 1'b0);
    chk("R7 adc burst err", rule_err, 1'b1);
    idle(); idle();
    chk("R7 sticky holds", rule_err, 1'b1);
    cyc(4'b1110, 6'h0, 2'd0, 1'b0, ADC_A, OTHER_D, 8'h00, 1'b1);
    chk("R7 clear", rule_err, 1'b0);
    cyc(4'b1000, 6'b100100, 2'b00, 1'b1, OTHER_S, TX_A[1], 8'h08, 1'b0);
    chk("R5 uart tx burst blocked", req, 1'b0);
    chk("R7 uart burst err", rule_err, 1'b1);
    cyc(4'b1000, 6'b010000, 2'b01, 1'b1, RX_A[2], OTHER_D, 8'h80, 1'b1);
    chk("R5 uart rx burst blocked", req, 1'b0);
    chk("R7 set wins over clear", rule_err, 1'b1);
    cyc(4'b1111, 6'h0, 2'd0, 1'b0, OTHER_S, OTHER_D, 8'h00, 1'b1);
    chk("R7 clear again", rule_err, 1'b0);

    // R6 addresses
    cyc(4'b1000, 6'b100010, 2'b00, 1'b0, OTHER_S, OTHER_D, 8'h04, 1'b0);
    chk("R6 tx wrong dst", req, 1'b0);
    chk("R7 tx wrong dst err", rule_err, 1'b1);
    cyc(4'b1000, 6'b100010, 2'b00, 1'b0, RX_A[0], TX_A[0], 8'h04, 1'b1);
    chk("R6 tx src free", req, 1'b1);
    chk("R7 cleared", rule_err, 1'b0);
    cyc(4'b1000, 6'b100100, 2'b00, 1'b0, OTHER_S, TX_A[0], 8'h08, 1'b0);
    chk("R6 tx other port addr", req, 1'b0);
    cyc(4'b1000, 6'b100100, 2'b01, 1'b0, RX_A[0], TX_A[1], 8'h40, 1'b1);
    chk("R6 rx other port addr", req, 1'b0);
    cyc(4'b1000, 6'b010000, 2'b01, 1'b0, RX_A[2], 16'hFFFF, 8'h80, 1'b1);
    chk("R6 rx dst free", req, 1'b1);
    cyc(4'b1110, 6'h0, 2'd0, 1'b0, 16'h4001, ADC_A, 8'h01, 1'b1);
    chk("R6 adc wrong src", req, 1'b0);
    cyc(4'b1110, 6'h3F, 2'd3, 1'b0, ADC_A, 16'h0000, 8'h01, 1'b1);
    chk("R6 adc dst free", req, 1'b1);
    cyc(4'b1111, 6'h3F, 2'd3, 1'b0, 16'hDEAD, 16'hBEEF, 8'h02, 1'b1);
    chk("R6 tmr any addr", req, 1'b1);
    idle();
    chk("R8 req drops one cycle after input", req, 1'b0);
    chk("R7 final err clear", rule_err, 1'b0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule